// File: doc/BRIEF.md
# Interrupt Enable and Priority Register Bank

This block is the software-visible configuration store in front of a vectored interrupt arbiter. For every interrupt line it keeps one enable bit and one 8-bit priority byte. It also keeps a 3-bit priority-group field that tells the arbiter how to split each priority byte into a preemption part and a sub-priority part. A simple synchronous register bus reaches all of this state. The bus carries a word address, a write strobe, 32-bit write data and registered read data. The arbiter receives the live enable vector, the priority bytes and the group field straight from the bank's flops.

Enable words are set-only: software enables a line by writing a 1 to its bit, and a 0 in the write data has no effect. A priority byte stores only its upper `PRIO_BITS` bits, and the lower bits always read as zero. The group field sits in a control word that is protected by a 16-bit key. A control write with any other key is dropped.

Top module: `ie_regbank`

## Requirements
- R1: After reset every enable bit, every priority byte and the group field are zero, and `rd_data` is zero.
- R2: A write to enable word w (word address 0x00 + w, w from 0 to 7) sets each line `32*w + b` whose write-data bit b is 1. Bits written as 0 leave their lines unchanged. Line n therefore lives in bit n&31 of word n>>5.
- R3: Reading an enable word returns the current enable bits of its lines. Bit positions that belong to no existing line (line index at or beyond `NUM_LINES`) read as zero, and writes to them have no effect.
- R4: Priority word k (word address 0x40 + k) holds lines 4k to 4k+3, with line 4k+b in bits [8b+7:8b]. Only the top `PRIO_BITS` bits of each byte are stored, and the remaining low bits read as zero. With `PRIO_BITS`=4, a byte written as 0xFF reads back as 0xF0.
- R5: Priority bytes of lines at or beyond `NUM_LINES` read as zero and ignore writes.
- R6: The control word at word address 0x80 holds the group field in bits [10:8]. A write updates that field only when write-data bits [31:16] equal 0x05FA. All other write-data bits are ignored.
- R7: A control write whose bits [31:16] differ from 0x05FA leaves the group field unchanged.
- R8: A read of the control word returns 0xFA05 in bits [31:16], the group field in bits [10:8], and zero in all other bits.
- R9: `rd_data` is registered. It shows the word at the address presented in the previous cycle, as that word stood before any write in that same cycle. Addresses outside the three regions read as zero.
- R10: `line_en`, `line_prio` and `prio_group` show a write's effect right after the clock edge that accepts it. They do not change in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Word address |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| line_en | output | NUM_LINES | Enable bit per line |
| line_prio | output | 8*NUM_LINES | Priority byte per line, line n at bits [8n+7:8n] |
| prio_group | output | 3 | Priority-group field |

## Verification
Every result in this bank is due one clock edge after its stimulus. A write changes the arbiter-side outputs at the edge that accepts it. A read address produces `rd_data` at the next edge, showing the state from before that edge. The driver presents each access half a cycle ahead of the rising edge and pushes the expected read word into a queue. The monitor pops that word one time unit after the following rising edge, so each comparison lands on exactly the edge where the registered data appears. Output ports are compared at the falling edge after a write, which also confirms that a write and a read of the same word in one cycle return the old value.

// File: rtl/ie_regbank_pkg.sv
// Package: shared constants of the interrupt enable/priority register bank.
// Assumes an 8-bit word address and a 32-bit data bus.
package ie_regbank_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int EN_IDX_W    = 3;     // up to 8 enable words
    localparam int PRIO_IDX_W  = 6;     // up to 64 priority words
    localparam int MAX_LINES   = 256;

    // Region selectors taken from addr[7:6]
    localparam logic [1:0] REG_EN   = 2'b00;
    localparam logic [1:0] REG_PRIO = 2'b01;
    localparam logic [1:0] REG_CTRL = 2'b10;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h80;
    localparam logic [15:0]       WR_KEY    = 16'h05FA;
    localparam logic [15:0]       RD_KEY    = 16'hFA05;
endpackage

// File: rtl/ie_enable_bank.sv
// Module: set-only enable bits, 32 lines per word.
// Assumes NUM_LINES <= 256. Bits for lines that do not exist hold no storage.
module ie_enable_bank
    import ie_regbank_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sel,
    input  logic [EN_IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [EN_IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0]    rd_word,
    output logic [NUM_LINES-1:0] line_en
);
    // Set each addressed line whose data bit is 1; zeros are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_en <= '0;
        end else if (wr_sel) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if ((EN_IDX_W'(i / 32) == wr_idx) && wr_data[i % 32]) begin
                    line_en[i] <= 1'b1;
                end
            end
        end
    end

    // Gather the enable bits of the word being read.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (EN_IDX_W'(i / 32) == rd_idx) begin
                rd_word[i % 32] = line_en[i];
            end
        end
    end
endmodule

// File: rtl/ie_prio_bank.sv
// Module: per-line priority bytes storing only the top PRIO_BITS bits.
// Assumes 1 <= PRIO_BITS <= 8 and NUM_LINES <= 256. Four lines share a word.
module ie_prio_bank
    import ie_regbank_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int PRIO_BITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_sel,
    input  logic [PRIO_IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [PRIO_IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0]      rd_word,
    output logic [8*NUM_LINES-1:0] line_prio
);
    localparam int LOW_ZERO = 8 - PRIO_BITS;

    logic [PRIO_BITS-1:0] prio_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Capture the upper bits of this line's byte on a write to its word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g] <= '0;
            end else if (wr_sel && (wr_idx == PRIO_IDX_W'(g / 4))) begin
                prio_q[g] <= wr_data[(g % 4) * 8 + 7 -: PRIO_BITS];
            end
        end

        // Present the byte with its unimplemented low bits at zero.
        assign line_prio[g*8 +: 8] = 8'(prio_q[g]) << LOW_ZERO;
    end

    // Gather the four bytes of the word being read.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (PRIO_IDX_W'(i / 4) == rd_idx) begin
                rd_word[(i % 4) * 8 +: 8] = line_prio[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/ie_ctrl_reg.sv
// Module: keyed control word holding the 3-bit priority-group field.
// Assumes the caller asserts wr_sel only for the control address.
module ie_ctrl_reg
    import ie_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word,
    output logic [2:0]        prio_group
);
    logic key_ok;

    // Accept a write only when the key half matches.
    assign key_ok = (wr_data[31:16] == WR_KEY);

    // Update the group field on a keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_group <= '0;
        end else if (wr_sel && key_ok) begin
            prio_group <= wr_data[10:8];
        end
    end

    // Read image: fixed key constant on top, group field in [10:8].
    assign rd_word = {RD_KEY, 5'b0, prio_group, 8'b0};
endmodule

// File: rtl/ie_regbank.sv
// Module: top of the interrupt enable/priority register bank.
// Decodes the word address into the enable, priority and control regions,
// and registers the read data. Assumes NUM_LINES <= 256 and 1 <= PRIO_BITS <= 8.
module ie_regbank
    import ie_regbank_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int PRIO_BITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NUM_LINES-1:0]   line_en,
    output logic [8*NUM_LINES-1:0] line_prio,
    output logic [2:0]             prio_group
);
    logic hit_en, hit_prio, hit_ctrl;
    logic [DATA_W-1:0] en_word, prio_word, ctrl_word;
    logic [DATA_W-1:0] rd_next;

    // Region decode from the upper address bits.
    assign hit_en   = (addr[7:6] == REG_EN) && (addr[5:3] == 3'b000);
    assign hit_prio = (addr[7:6] == REG_PRIO);
    assign hit_ctrl = (addr == CTRL_ADDR);

    ie_enable_bank #(.NUM_LINES(NUM_LINES)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_en && hit_en),
        .wr_idx  (addr[EN_IDX_W-1:0]),
        .wr_data (wr_data),
        .rd_idx  (addr[EN_IDX_W-1:0]),
        .rd_word (en_word),
        .line_en (line_en)
    );

    ie_prio_bank #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_en && hit_prio),
        .wr_idx    (addr[PRIO_IDX_W-1:0]),
        .wr_data   (wr_data),
        .rd_idx    (addr[PRIO_IDX_W-1:0]),
        .rd_word   (prio_word),
        .line_prio (line_prio)
    );

    ie_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_en && hit_ctrl),
        .wr_data    (wr_data),
        .rd_word    (ctrl_word),
        .prio_group (prio_group)
    );

    // Select the addressed region's word; unmapped addresses give zero.
    always_comb begin
        if (hit_en)        rd_next = en_word;
        else if (hit_prio) rd_next = prio_word;
        else if (hit_ctrl) rd_next = ctrl_word;
        else               rd_next = '0;
    end

    // Register the read word (pre-write state of this cycle).
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end
endmodule

// File: rtl/ie_regbank_chk.sv
// Module: assertion checker bound to ie_regbank; observes ports only.
module ie_regbank_chk
    import ie_regbank_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int PRIO_BITS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      addr,
    input logic                   wr_en,
    input logic [DATA_W-1:0]      wr_data,
    input logic [DATA_W-1:0]      rd_data,
    input logic [NUM_LINES-1:0]   line_en,
    input logic [8*NUM_LINES-1:0] line_prio,
    input logic [2:0]             prio_group
);
    // R2: enable bits only ever go from 0 to 1.
    a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((line_en & $past(line_en)) == $past(line_en)));

    // R6/R7: the group field moves only on a keyed control write.
    a_r7_group_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == CTRL_ADDR && wr_data[31:16] == WR_KEY) |=> $stable(prio_group));

    // R10: without a write the enable vector holds.
    a_r10_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(line_en));

    // R10: without a write the priority bytes hold.
    a_r10_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(line_prio));

    // R8: control reads carry the fixed key image in the upper half.
    a_r8_ctrl_key_image: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTRL_ADDR) |=> (rd_data[31:16] == RD_KEY));

    // R9: the top address quarter is unmapped and reads zero.
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[7:6] == 2'b11) |=> (rd_data == '0));
endmodule

bind ie_regbank ie_regbank_chk #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .line_en    (line_en),
    .line_prio  (line_prio),
    .prio_group (prio_group)
);

// File: tb/sim_ie_regbank.sv
// Bench: scoreboard for ie_regbank with the default parameters (64 lines, 4 priority bits).
module sim_ie_regbank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [63:0]  line_en;
    logic [511:0] line_prio;
    logic [2:0]   prio_group;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    ie_regbank u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .line_en(line_en), .line_prio(line_prio), .prio_group(prio_group)
    );

    // Compare one value and count the check.
    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: the registered read word is due one edge after its request.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, {32'b0, rd_data}, {32'b0, it.exp});
        end
    end

    // Driver: read request, expected word goes to the scoreboard.
    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b0; wr_data = '0;
        sb.push_back('{exp: exp, tag: tag});
        @(negedge clk);
    endtask

    // Driver: write; returns at the falling edge after the accepting edge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hC0;
    endtask

    // Driver: write while also checking the read word from the same cycle.
    task automatic wr_rd(logic [7:0] a, logic [31:0] d, logic [31:0] exp, string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        sb.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        wr_en = 1'b0; addr = 8'hC0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enables", line_en, 64'h0);
        check("R1 prio low", line_prio[63:0], 64'h0);
        check("R1 prio high", line_prio[511:448], 64'h0);
        check("R1 group", {61'b0, prio_group}, 64'h0);
        check("R1 rd_data", {32'b0, rd_data}, 64'h0);
        rd(8'h80, 32'hFA05_0000, "R1/R8 ctrl after reset");

        // R2: set-only enable writes
        wr(8'h00, 32'h0000_0005);
        wr(8'h00, 32'h0000_0010);
        rd(8'h00, 32'h0000_0015, "R2 zeros leave bits set");
        check("R2 line 4 enabled", {63'b0, line_en[4]}, 64'h1);
        wr(8'h01, 32'h8000_0001);
        check("R2 lines 32 and 63", line_en, 64'h8000_0001_0000_0015);
        rd(8'h01, 32'h8000_0001, "R3 word 1 readback");

        // R3: word beyond the line count
        wr(8'h02, 32'hFFFF_FFFF);
        rd(8'h02, 32'h0, "R3 missing lines read zero");
        check("R3 write to missing lines", line_en, 64'h8000_0001_0000_0015);

        // R4/R5: priority bytes
        wr(8'h40, 32'hFFA5_3CFF);
        rd(8'h40, 32'hF0A0_30F0, "R4 low bits read zero");
        check("R4 line 0 port", {56'b0, line_prio[7:0]}, 64'hF0);
        wr(8'h4F, 32'h1234_5678);
        rd(8'h4F, 32'h1030_5070, "R4 lines 60..63");
        check("R4 line 63 port", {56'b0, line_prio[511:504]}, 64'h10);
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 32'h0, "R5 missing lines read zero");
        rd(8'h40, 32'hF0A0_30F0, "R5 no spill into word 0");

        // R6/R7/R8: keyed control word
        wr(8'h80, 32'h05FA_0500);
        check("R6 keyed write", {61'b0, prio_group}, 64'h5);
        rd(8'h80, 32'hFA05_0500, "R8 ctrl image");
        wr(8'h80, 32'h1234_0300);
        check("R7 wrong key ignored", {61'b0, prio_group}, 64'h5);
        wr(8'h80, 32'hFA05_0200);
        check("R7 read image as key ignored", {61'b0, prio_group}, 64'h5);
        wr(8'h80, 32'h05FA_07FF);
        check("R6 other bits ignored", {61'b0, prio_group}, 64'h7);
        rd(8'h80, 32'hFA05_0700, "R8 ctrl image after update");

        // R9: unmapped addresses and read-during-write ordering
        rd(8'h90, 32'h0, "R9 unmapped 0x90");
        rd(8'h08, 32'h0, "R9 unmapped 0x08");
        wr_rd(8'h00, 32'h0000_0100, 32'h0000_0015, "R9 read shows pre-write state");
        rd(8'h00, 32'h0000_0115, "R9 read after write");

        // R10: outputs hold across idle cycles
        repeat (4) @(negedge clk);
        check("R10 enables hold", line_en, 64'h8000_0001_0000_0115);
        check("R10 prio hold", {56'b0, line_prio[15:8]}, 64'h30);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule